// File: doc/BRIEF.md
# Microprogrammed Test Pattern Sequencer

This block steps through a wide control-word memory and turns each word into a registered drive vector for a device under test. The vector holds 22 stimulus bits, a 12-bit code for an external DAC and five timing strobes. The strobes are a scope trigger, an ADC convert, a store-ADC-sample strobe, a store-digital-sample strobe and a strobe that raises the acquisition side's request flag. The word's own control fields choose the next address, so the pattern memory steers itself. These fields are a 4-bit opcode, a 12-bit operand, a 3-bit flag select and a step-length bit. The sequencer can jump, loop on a counter, call and return through a five-entry return stack, and branch on one of eight external flags. One of those flags is usually the acquisition handshake.

A host fills the memory in 16-bit slices while the sequencer is idle. A pulse on either the panel start or the host start begins execution at address 0. Each word lasts one base clock (short step) or three base clocks (long step). All outputs change only on the clock edge that closes a step. A typical program repeats a stimulus routine until the handshake flag rises, then runs a counted readout loop, for example 128 passes, and halts.

Top module: `microseq_top`

## Requirements
- R1: After reset, stim_out, dac_out and strobe_out are zero, and running, done and stack_err are low.
- R2: When the sequencer is idle, a high start_panel or start_host at a clock edge sets running and loads the fields of word 0 onto the outputs at that edge. While the sequencer is running, a start pulse is ignored.
- R3: A word whose bit 19 is 1 lasts three clocks; otherwise it lasts one clock. Outputs change only on the edge that ends a step.
- R4: Opcodes (bits 3:0): 0 halt, 1 next, 2 jump to the operand, and 9 to 15 act as next. The next address is the current address plus one, wrapping at the memory size. A jump target is the operand's low 11 bits.
- R5: Opcode 3 jumps when ext_flags[sel] is 1, and opcode 4 jumps when it is 0; otherwise each continues to the next address. sel is bits 18:16. The flag is sampled on the edge that ends the step.
- R6: Opcode 5 loads the 12-bit operand into the loop counter and continues. Opcode 6 jumps to the operand and decrements the counter when the counter is nonzero; otherwise it continues. Loading N therefore runs the loop body N+1 times.
- R7: Opcode 7 pushes address+1 and jumps to the operand. Opcode 8 pops into the address. The stack holds 5 entries and is last-in first-out.
- R8: A call with 5 entries already stacked, or a return with none, sets stack_err, which stays set until reset. It also clears running and zeroes strobe_out, leaves stim_out and dac_out holding, and leaves done low.
- R9: A halt word, at the end of its step, clears running, sets done, zeroes strobe_out and leaves stim_out and dac_out holding. Start clears done.
- R10: When wr_en is high with running low, wr_data is written to the slice wr_slice (bits 16*s+15:16*s) of the word at wr_addr. While running is high, writes are ignored.
- R11: Word layout: operand bits 15:4, stimulus bits 41:20 and DAC code bits 53:42. Strobes occupy bits 58:54 in this order from bit 54: scope, ADC convert, store ADC, store digital, set flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_panel | input | 1 | Start request from the panel |
| start_host | input | 1 | Start request from the host |
| ext_flags | input | 8 | External branch flags, one chosen per word |
| wr_en | input | 1 | Program write strobe |
| wr_addr | input | 11 | Program write word address |
| wr_slice | input | 2 | 16-bit slice of the word being written |
| wr_data | input | 16 | Slice data |
| stim_out | output | 22 | Digital stimulus to the device under test |
| dac_out | output | 12 | Code for the external DAC |
| strobe_out | output | 5 | Scope, convert, store-ADC, store-digital, set-flag strobes |
| running | output | 1 | Sequencer executing |
| done | output | 1 | Halt reached |
| stack_err | output | 1 | Sticky stack overflow or underflow |

## Verification
Every control decision becomes visible at the ports within one step, because the word loaded at the step's last edge puts its own stimulus on stim_out. A wrong next address, a bad counter decrement or a mispopped return address therefore shows up as the wrong stimulus value in the very next step. A step-length error shows up as a stimulus change one or two clocks too early or too late. A lost or extra stack entry may stay hidden until the matching return or the fifth nested call, where it shows as the wrong stimulus or a stack_err that comes too early or too late. The bench gives every program word a distinct stimulus value. A cycle-by-cycle model then compares all outputs on every clock, so a divergence is caught on the clock where it first appears.

// File: rtl/microseq_pkg.sv
package microseq_pkg;
  localparam int CMD_W   = 4;
  localparam int DATA_W  = 12;
  localparam int SEL_W   = 3;
  localparam int STIM_W  = 22;
  localparam int DAC_W   = 12;
  localparam int STRB_W  = 5;
  localparam int SLICE_W = 16;
  localparam int FLAG_W  = 1 << SEL_W;
  localparam int WORD_W  = CMD_W + DATA_W + SEL_W + 1 + STIM_W + DAC_W + STRB_W;
  localparam int SLICES  = (WORD_W + SLICE_W - 1) / SLICE_W;
  localparam int SS_W    = (SLICES > 1) ? $clog2(SLICES) : 1;

  localparam logic [CMD_W-1:0] OP_HALT = 4'd0;
  localparam logic [CMD_W-1:0] OP_NEXT = 4'd1;
  localparam logic [CMD_W-1:0] OP_GOTO = 4'd2;
  localparam logic [CMD_W-1:0] OP_BRT  = 4'd3;
  localparam logic [CMD_W-1:0] OP_BRF  = 4'd4;
  localparam logic [CMD_W-1:0] OP_SETC = 4'd5;
  localparam logic [CMD_W-1:0] OP_LOOP = 4'd6;
  localparam logic [CMD_W-1:0] OP_CALL = 4'd7;
  localparam logic [CMD_W-1:0] OP_RET  = 4'd8;

  typedef struct packed {
    logic [STRB_W-1:0] strb;
    logic [DAC_W-1:0]  dac;
    logic [STIM_W-1:0] stim;
    logic              lng;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] data;
    logic [CMD_W-1:0]  cmd;
  } uword_t;
endpackage

// File: rtl/microseq_store.sv
module microseq_store
  import microseq_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [SS_W-1:0]    wslice,
  input  logic [SLICE_W-1:0] wdata,
  input  logic [AW-1:0]      raddr,
  output uword_t             rdata
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] flat;

  for (genvar s = 0; s < SLICES; s++) begin : g_bank
    localparam int BW = (s == SLICES - 1) ? (WORD_W - SLICE_W * s) : SLICE_W;
    logic [BW-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we && (wslice == SS_W'(s))) bank[waddr] <= wdata[BW-1:0];
    end

    assign flat[SLICE_W*s +: BW] = bank[raddr];
  end

  assign rdata = uword_t'(flat);
endmodule

// File: rtl/microseq_timer.sv
module microseq_timer #(
  parameter int LONG_CLKS  = 3,
  parameter int SHORT_CLKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic long_step,
  output logic step_end
);
  localparam int CW = (LONG_CLKS > 1) ? $clog2(LONG_CLKS) : 1;

  function automatic logic [CW-1:0] last_tick(input logic lng);
    return lng ? CW'(LONG_CLKS - 1) : CW'(SHORT_CLKS - 1);
  endfunction

  logic [CW-1:0] tick;

  assign step_end = active && (tick == last_tick(long_step));

  always_ff @(posedge clk) begin
    if (!rst_n)                   tick <= '0;
    else if (!active || step_end) tick <= '0;
    else                          tick <= tick + 1'b1;
  end
endmodule

// File: rtl/microseq_stack.sv
module microseq_stack #(
  parameter int DEPTH = 5,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] tos,
  output logic          full,
  output logic          empty,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int LW = $clog2(DEPTH + 1);

  logic [AW-1:0] slot [DEPTH];

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign tos   = empty ? '0 : slot[level - 1'b1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= '0;
    end else if (push && !full) begin
      slot[level] <= din;
      level       <= level + 1'b1;
    end else if (pop && !empty) begin
      level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/microseq_next.sv
module microseq_next
  import microseq_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic [CMD_W-1:0]  cmd,
  input  logic [DATA_W-1:0] data,
  input  logic              cond,
  input  logic              cnt_zero,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     tos,
  input  logic              full,
  input  logic              empty,
  output logic [AW-1:0]     nxt_pc,
  output logic              push,
  output logic              pop,
  output logic              cnt_ld,
  output logic              cnt_dec,
  output logic              halt,
  output logic              serr
);
  function automatic logic [AW-1:0] target(input logic [DATA_W-1:0] d);
    return d[AW-1:0];
  endfunction

  always_comb begin
    nxt_pc  = pc + 1'b1;
    push    = 1'b0;
    pop     = 1'b0;
    cnt_ld  = 1'b0;
    cnt_dec = 1'b0;
    halt    = 1'b0;
    serr    = 1'b0;
    case (cmd)
      OP_HALT: halt = 1'b1;
      OP_GOTO: nxt_pc = target(data);
      OP_BRT:  if (cond)  nxt_pc = target(data);
      OP_BRF:  if (!cond) nxt_pc = target(data);
      OP_SETC: cnt_ld = 1'b1;
      OP_LOOP: begin
        if (!cnt_zero) begin
          cnt_dec = 1'b1;
          nxt_pc  = target(data);
        end
      end
      OP_CALL: begin
        if (full) begin
          serr   = 1'b1;
          nxt_pc = pc;
        end else begin
          push   = 1'b1;
          nxt_pc = target(data);
        end
      end
      OP_RET: begin
        if (empty) begin
          serr   = 1'b1;
          nxt_pc = pc;
        end else begin
          pop    = 1'b1;
          nxt_pc = tos;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/microseq_top.sv
module microseq_top
  import microseq_pkg::*;
#(
  parameter int AW         = 11,
  parameter int STK_DEPTH  = 5,
  parameter int LONG_CLKS  = 3,
  parameter int SHORT_CLKS = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_panel,
  input  logic               start_host,
  input  logic [FLAG_W-1:0]  ext_flags,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [SS_W-1:0]    wr_slice,
  input  logic [SLICE_W-1:0] wr_data,
  output logic [STIM_W-1:0]  stim_out,
  output logic [DAC_W-1:0]   dac_out,
  output logic [STRB_W-1:0]  strobe_out,
  output logic               running,
  output logic               done,
  output logic               stack_err
);
  localparam int LW = $clog2(STK_DEPTH + 1);

  uword_t            cur_q;
  uword_t            rd_word;
  logic [AW-1:0]     pc;
  logic [AW-1:0]     rd_addr;
  logic [DATA_W-1:0] loop_cnt;

  logic          step_end, start_fire, mem_we, cond;
  logic [AW-1:0] nxt_pc, tos;
  logic          do_push, do_pop, do_ld, do_dec, do_halt, do_serr;
  logic          stk_full, stk_empty;
  logic [LW-1:0] stk_level;
  logic          halt_ev, serr_ev;

  assign start_fire = (start_panel | start_host) & ~running;
  assign mem_we     = wr_en & ~running;
  assign cond       = ext_flags[cur_q.sel];
  assign halt_ev    = step_end & do_halt;
  assign serr_ev    = step_end & do_serr;
  assign rd_addr    = running ? nxt_pc : '0;

  microseq_store #(.AW(AW)) u_store (
    .clk    (clk),
    .we     (mem_we),
    .waddr  (wr_addr),
    .wslice (wr_slice),
    .wdata  (wr_data),
    .raddr  (rd_addr),
    .rdata  (rd_word)
  );

  microseq_timer #(.LONG_CLKS(LONG_CLKS), .SHORT_CLKS(SHORT_CLKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (running),
    .long_step (cur_q.lng),
    .step_end  (step_end)
  );

  microseq_next #(.AW(AW)) u_next (
    .cmd      (cur_q.cmd),
    .data     (cur_q.data),
    .cond     (cond),
    .cnt_zero (loop_cnt == '0),
    .pc       (pc),
    .tos      (tos),
    .full     (stk_full),
    .empty    (stk_empty),
    .nxt_pc   (nxt_pc),
    .push     (do_push),
    .pop      (do_pop),
    .cnt_ld   (do_ld),
    .cnt_dec  (do_dec),
    .halt     (do_halt),
    .serr     (do_serr)
  );

  microseq_stack #(.DEPTH(STK_DEPTH), .AW(AW)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (step_end & do_push),
    .pop   (step_end & do_pop),
    .din   (pc + 1'b1),
    .tos   (tos),
    .full  (stk_full),
    .empty (stk_empty),
    .level (stk_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      done      <= 1'b0;
      stack_err <= 1'b0;
      pc        <= '0;
      loop_cnt  <= '0;
      cur_q     <= '0;
    end else if (start_fire) begin
      running <= 1'b1;
      done    <= 1'b0;
      pc      <= '0;
      cur_q   <= rd_word;
    end else if (step_end) begin
      if (do_halt || do_serr) begin
        running    <= 1'b0;
        done       <= do_halt;
        stack_err  <= stack_err | do_serr;
        cur_q.strb <= '0;
      end else begin
        pc    <= nxt_pc;
        cur_q <= rd_word;
      end
      if (do_ld)       loop_cnt <= cur_q.data;
      else if (do_dec) loop_cnt <= loop_cnt - 1'b1;
    end
  end

  assign stim_out   = cur_q.stim;
  assign dac_out    = cur_q.dac;
  assign strobe_out = cur_q.strb;
endmodule

// File: rtl/microseq_chk.sv
module microseq_chk #(
  parameter int DEPTH = 5,
  parameter int LW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          running,
  input logic          done,
  input logic          stack_err,
  input logic [21:0]   stim_out,
  input logic [11:0]   dac_out,
  input logic [4:0]    strobe_out,
  input logic          step_end,
  input logic          start_fire,
  input logic          halt_ev,
  input logic          serr_ev,
  input logic          mem_we,
  input logic [LW-1:0] stk_level
);
  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> running);

  assert_hold_in_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !step_end) |=> ($stable(stim_out) && $stable(dac_out) && $stable(strobe_out)));

  assert_stack_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stk_level <= LW'(DEPTH));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err);

  assert_err_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    serr_ev |=> (!running && stack_err && !done && strobe_out == 5'd0));

  assert_halt_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt_ev |=> (done && !running && strobe_out == 5'd0 && $stable(stim_out)));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !running);

  assert_no_write_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !running);
endmodule

bind microseq_top microseq_chk #(.DEPTH(STK_DEPTH), .LW(LW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .running    (running),
  .done       (done),
  .stack_err  (stack_err),
  .stim_out   (stim_out),
  .dac_out    (dac_out),
  .strobe_out (strobe_out),
  .step_end   (step_end),
  .start_fire (start_fire),
  .halt_ev    (halt_ev),
  .serr_ev    (serr_ev),
  .mem_we     (mem_we),
  .stk_level  (stk_level)
);

// File: tb/sim_microseq_top.sv
module sim_microseq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_panel = 1'b0, start_host = 1'b0;
  logic [7:0]  ext_flags = '0;
  logic        wr_en = 1'b0;
  logic [10:0] wr_addr = '0;
  logic [1:0]  wr_slice = '0;
  logic [15:0] wr_data = '0;
  logic [21:0] stim_out;
  logic [11:0] dac_out;
  logic [4:0]  strobe_out;
  logic        running, done, stack_err;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  microseq_top u0 (.*);

  function automatic logic [58:0] mk(input logic [3:0] op, input logic [11:0] d,
      input logic [2:0] sel, input logic lng, input logic [21:0] stim,
      input logic [11:0] dac, input logic [4:0] strb);
    return {strb, dac, stim, lng, sel, d, op};
  endfunction

  // main program: counter loop, nested calls, flag branch, unused opcode, long steps
  localparam int NP = 14;
  localparam logic [58:0] PROG1 [NP] = '{
    mk(4'd5, 12'd2,  3'd0, 1'b0, 22'd1,  12'h000, 5'h00),
    mk(4'd1, 12'd0,  3'd0, 1'b1, 22'd2,  12'h000, 5'h01),
    mk(4'd6, 12'd1,  3'd0, 1'b0, 22'd3,  12'h000, 5'h00),
    mk(4'd7, 12'd10, 3'd0, 1'b0, 22'd4,  12'h000, 5'h00),
    mk(4'd3, 12'd7,  3'd2, 1'b0, 22'd5,  12'h000, 5'h02),
    mk(4'd13,12'd0,  3'd0, 1'b0, 22'd6,  12'h123, 5'h00),
    mk(4'd0, 12'd0,  3'd0, 1'b0, 22'd7,  12'h456, 5'h10),
    mk(4'd2, 12'd6,  3'd0, 1'b1, 22'd8,  12'hABC, 5'h04),
    mk(4'd0, 12'd0,  3'd0, 1'b0, 22'd0,  12'h000, 5'h00),
    mk(4'd0, 12'd0,  3'd0, 1'b0, 22'd0,  12'h000, 5'h00),
    mk(4'd7, 12'd12, 3'd0, 1'b0, 22'd9,  12'h000, 5'h00),
    mk(4'd8, 12'd0,  3'd0, 1'b0, 22'd10, 12'h000, 5'h00),
    mk(4'd1, 12'd0,  3'd0, 1'b1, 22'd11, 12'h000, 5'h02),
    mk(4'd8, 12'd0,  3'd0, 1'b0, 22'd12, 12'h000, 5'h08)
  };

  // reference model state
  logic [58:0] bm [64];
  int epc, erem, esp, ecnt;
  int estk [8];
  bit erun, edone, eerr, estarted;
  logic [21:0] estim;
  logic [11:0] edac;
  logic [4:0]  estrb;
  int rises;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    erun = 0; edone = 0; eerr = 0; esp = 0; ecnt = 0; epc = 0; erem = 0;
    estim = '0; edac = '0; estrb = '0;
  endtask

  task automatic model_load(input int a);
    logic [58:0] w;
    w = bm[a];
    estim = w[41:20]; edac = w[53:42]; estrb = w[58:54];
    erem = w[19] ? 3 : 1;
  endtask

  task automatic model_exec();
    logic [58:0] w;
    int op, d, np;
    bit c, stop, bad;
    w = bm[epc];
    op = int'(w[3:0]); d = int'(w[15:4]); c = ext_flags[w[18:16]];
    np = (epc + 1) % 2048; stop = 0; bad = 0;
    case (op)
      0: stop = 1;
      2: np = d % 2048;
      3: if (c) np = d % 2048;
      4: if (!c) np = d % 2048;
      5: ecnt = d;
      6: if (ecnt != 0) begin ecnt--; np = d % 2048; end
      7: if (esp == 5) bad = 1; else begin estk[esp] = (epc + 1) % 2048; esp++; np = d % 2048; end
      8: if (esp == 0) bad = 1; else begin esp--; np = estk[esp]; end
      default: ;
    endcase
    if (stop) begin erun = 0; edone = 1; estrb = '0; end
    else if (bad) begin erun = 0; eerr = 1; estrb = '0; end
    else begin epc = np; model_load(epc); end
  endtask

  task automatic model_edge();
    logic [63:0] t;
    bit was_run;
    was_run = erun;
    if (!was_run) begin
      if (start_panel || start_host) begin
        erun = 1; estarted = 1; edone = 0; epc = 0; model_load(0);
      end
    end else begin
      erem--;
      if (erem == 0) model_exec();
    end
    if (wr_en && !was_run && wr_addr < 64) begin
      t = {5'b0, bm[wr_addr]};
      t[wr_slice*16 +: 16] = wr_data;
      bm[wr_addr] = t[58:0];
    end
  endtask

  task automatic write_word(input int a, input logic [58:0] w);
    logic [63:0] t;
    t = {5'b0, w};
    for (int s = 0; s < 4; s++) begin
      wr_en = 1; wr_addr = 11'(a); wr_slice = 2'(s); wr_data = t[s*16 +: 16];
      @(posedge clk);
      model_edge();
      @(negedge clk);
    end
    wr_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic run_prog(input string tag, input int max_cyc, input bit panel,
      input int flag_idx, input int flag_at, input int wr_at, input int st_at);
    int post;
    bit prev;
    post = 0; prev = 0; rises = 0; estarted = 0;
    ext_flags = '0;
    if (panel) start_panel = 1; else start_host = 1;
    for (int cyc = 0; cyc < max_cyc; cyc++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk(tag, {running, done, stack_err, strobe_out, dac_out, stim_out},
               {erun, edone, eerr, estrb, edac, estim});
      if (strobe_out[3] && !prev) rises++;
      prev = strobe_out[3];
      start_panel = 0; start_host = 0; wr_en = 0;
      if (cyc + 1 == st_at) start_host = 1;
      if (cyc + 1 == wr_at) begin
        wr_en = 1; wr_addr = 11'd1; wr_slice = 2'd1; wr_data = 16'hFFFF;
      end
      if (flag_at >= 0 && cyc + 1 >= flag_at) ext_flags[flag_idx] = 1'b1;
      if (estarted && !erun) post++;
      if (post > 3) break;
    end
    wr_en = 0; ext_flags = '0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) bm[i] = '0;
    model_reset();
    do_reset();
    // R1 reset state
    chk("R1", {running, done, stack_err, strobe_out, dac_out, stim_out}, 64'd0);

    // load main program from the table
    for (int a = 0; a < NP; a++) write_word(a, PROG1[a]);

    // flag low: falls through 5 then halts at 6 (R4 R5 R6 R7 R3 R11)
    run_prog("R3/R4/R5/R6/R7/R11 flag-low", 300, 1'b0, 2, -1, -1, -1);
    chk("R9 halt stimulus held", {44'd0, dac_out, stim_out[7:0]}, {44'd0, 12'h456, 8'd7});
    chk("R9 strobes cleared", {59'd0, strobe_out}, 64'd0);
    chk("R9 done set", {62'd0, done, running}, 64'd2);

    // flag high: branch to 7, long GOTO 6 (R5)
    run_prog("R5 flag-high", 300, 1'b1, 2, 0, -1, -1);
    chk("R5 halt reached via branch", {63'd0, done}, 64'd1);

    // wait-for-flag, write and start ignored while running (R2 R10)
    write_word(0, mk(4'd4, 12'd0, 3'd5, 1'b0, 22'h21, 12'h000, 5'h00));
    write_word(1, mk(4'd1, 12'd0, 3'd0, 1'b0, 22'h22, 12'h001, 5'h08));
    write_word(2, mk(4'd0, 12'd0, 3'd0, 1'b0, 22'h23, 12'h002, 5'h00));
    run_prog("R2/R5/R10 wait", 200, 1'b1, 5, 20, 5, 8);
    chk("R10 write ignored while running", {42'd0, stim_out}, 64'h23);

    // idle write path works: new word 1 visible after restart (R10)
    write_word(1, mk(4'd1, 12'd0, 3'd0, 1'b0, 22'h77, 12'h001, 5'h00));
    run_prog("R10 idle write", 200, 1'b0, 5, 0, -1, -1);

    // counted readout loop: 128 store-digital strobes (R6)
    write_word(0, mk(4'd5, 12'd127, 3'd0, 1'b0, 22'h31, 12'h000, 5'h00));
    write_word(1, mk(4'd1, 12'd0,   3'd0, 1'b0, 22'h32, 12'h000, 5'h08));
    write_word(2, mk(4'd6, 12'd1,   3'd0, 1'b0, 22'h33, 12'h000, 5'h00));
    write_word(3, mk(4'd0, 12'd0,   3'd0, 1'b0, 22'h34, 12'h000, 5'h00));
    run_prog("R6 readout", 1000, 1'b1, 0, -1, -1, -1);
    chk("R6 128 readout passes", 64'(rises), 64'd128);

    // call overflow at sixth nesting (R7 R8)
    for (int a = 0; a < 6; a++)
      write_word(a, mk(4'd7, 12'(a + 1), 3'd0, 1'b0, 22'(16'h40 + a), 12'h0AA, 5'h01));
    run_prog("R7/R8 overflow", 200, 1'b0, 0, -1, -1, -1);
    chk("R8 overflow flags error, not done", {61'd0, stack_err, done, running}, 64'd4);
    chk("R8 address held at word 5", {42'd0, stim_out}, 64'h45);

    // sticky error survives a clean run; reset clears it (R8 R1)
    write_word(0, mk(4'd0, 12'd0, 3'd0, 1'b0, 22'h50, 12'h000, 5'h00));
    run_prog("R8 sticky", 50, 1'b1, 0, -1, -1, -1);
    chk("R8 error still set", {63'd0, stack_err}, 64'd1);
    do_reset();
    chk("R1 reset clears error", {61'd0, stack_err, done, running}, 64'd0);

    // return with empty stack (R8)
    write_word(0, mk(4'd8, 12'd0, 3'd0, 1'b0, 22'h60, 12'h000, 5'h02));
    run_prog("R8 underflow", 50, 1'b0, 0, -1, -1, -1);
    chk("R8 underflow error", {61'd0, stack_err, done, running}, 64'd4);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule